// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block folds a large set of level-sensitive interrupt sources into a smaller number of request lines for a parent interrupt controller. Sources are grouped eight at a time. Each group has its own output line. That line is high for as long as at least one enabled source of the group is high.

Four neighbouring groups share one 32-bit register bank, and each group occupies one byte lane of it. Software changes enable bits through two write-one registers: one sets bits and the other clears them. Because the set register reads back the live enable bits, software can save the enable state and restore it later. A status register shows which sources are both asserted and enabled, so a handler can find the source behind an active line.

Top module: `intr_combiner_top`

## Requirements
- R1: After reset every enable bit reads as zero, and every group output is low even while sources are high.
- R2: Writing to bank offset 0x0 sets each enable bit whose written bit is 1. Enable bits written as 0 keep their value. The change is visible from the clock edge that takes the write.
- R3: Writing to bank offset 0x4 clears each enable bit whose written bit is 1. Enable bits written as 0 keep their value.
- R4: Reading bank offset 0x0 returns the current enable bits of that bank.
- R5: Reading bank offset 0xC returns, bit by bit, the source level ANDed with its enable bit. Group n sits in bits [8*(n mod 4)+7 : 8*(n mod 4)] of the bank at byte address (n/4)*0x10.
- R6: Output line n is the OR of the enabled sources of group n, with no clock delay from the source. Source k belongs to group k/8 and occupies bit k mod 8 of that group's lane.
- R7: The following accesses are ignored and read as zero: writes or reads at bank offset 0x8, writes to offset 0xC, any address whose two low bits are not zero, and any address beyond the last bank. Reads of offset 0x4 also return zero.
- R8: A write to one bank leaves the enable bits of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_GROUPS*8 | Level interrupt sources, source k at bit k |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_we_i | input | 1 | Write strobe, takes effect at the clock edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| grp_irq_o | output | NUM_GROUPS | One request line per group |

## Verification
The hardest case is keeping one byte lane's traffic from spilling into its three neighbours, or into the same lane of another bank. From the ports this looks identical to a correct design unless the other lanes already hold distinct enable patterns and carry active sources. The bench first loads a different enable pattern into every bank. It then drives patterned source vectors and issues lane-sized set and clear writes. After each write it reads back every bank and compares all twenty output lines against a model.

// File: rtl/comb_pkg.sv
package comb_pkg;
    localparam int LANE_W         = 8;
    localparam int LANES_PER_BANK = 4;
    localparam int REG_W          = LANE_W * LANES_PER_BANK;

    typedef enum logic [1:0] {
        REG_SET  = 2'd0,
        REG_CLR  = 2'd1,
        REG_RSVD = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] en;
    } bank_state_t;
endpackage

// File: rtl/comb_bank.sv
module comb_bank
    import comb_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    sel_i,
    input  logic                    we_i,
    input  reg_sel_e                reg_i,
    input  logic [REG_W-1:0]        wdata_i,
    input  logic [LANES*LANE_W-1:0] src_i,
    output logic [REG_W-1:0]        en_o,
    output logic [REG_W-1:0]        stat_o,
    output logic [LANES-1:0]        irq_o
);
    localparam int VALID_BITS = LANES * LANE_W;
    localparam logic [REG_W-1:0] LANE_MASK = {REG_W{1'b1}} >> (REG_W - VALID_BITS);

    bank_state_t state_d, state_q;
    logic [REG_W-1:0] src_ext;

    assign src_ext = REG_W'(src_i);

    always_comb begin
        state_d = state_q;
        if (sel_i && we_i) begin
            case (reg_i)
                REG_SET: state_d.en = state_q.en | (wdata_i & LANE_MASK);
                REG_CLR: state_d.en = state_q.en & ~wdata_i;
                default: state_d.en = state_q.en;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign en_o   = state_q.en;
    assign stat_o = state_q.en & src_ext;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign irq_o[l] = |stat_o[l*LANE_W +: LANE_W];
    end

    // R2
    set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && we_i && reg_i == REG_SET)
        |=> ((en_o & $past(wdata_i & LANE_MASK)) == $past(wdata_i & LANE_MASK)));

    // R3
    clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && we_i && reg_i == REG_CLR) |=> ((en_o & $past(wdata_i)) == '0));

    // R7 R8
    hold_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sel_i && we_i && (reg_i == REG_SET || reg_i == REG_CLR)) |=> $stable(en_o));

    // R6
    irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_o) |-> (|en_o));
endmodule

// File: rtl/comb_rd_mux.sv
module comb_rd_mux
    import comb_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int BIDX_W    = 4
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             valid_i,
    input  logic [BIDX_W-1:0]                bank_i,
    input  reg_sel_e                         reg_i,
    input  logic [NUM_BANKS-1:0][REG_W-1:0]  en_i,
    input  logic [NUM_BANKS-1:0][REG_W-1:0]  stat_i,
    output logic [REG_W-1:0]                 rdata_o
);
    logic hit;

    always_comb begin
        rdata_o = '0;
        hit     = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (valid_i && bank_i == BIDX_W'(b)) begin
                hit = 1'b1;
                case (reg_i)
                    REG_SET:  rdata_o = en_i[b];
                    REG_STAT: rdata_o = stat_i[b];
                    default:  rdata_o = '0;
                endcase
            end
        end
    end

    // R7
    miss_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hit || reg_i == REG_CLR || reg_i == REG_RSVD) |-> (rdata_o == '0));
endmodule

// File: rtl/intr_combiner_top.sv
module intr_combiner_top
    import comb_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8,
    localparam int NUM_SRC   = NUM_GROUPS * LANE_W,
    localparam int NUM_BANKS = (NUM_GROUPS + LANES_PER_BANK - 1) / LANES_PER_BANK,
    localparam int BIDX_W    = ADDR_W - 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_SRC-1:0]    src_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic                  reg_we_i,
    input  logic [REG_W-1:0]      reg_wdata_i,
    output logic [REG_W-1:0]      reg_rdata_o,
    output logic [NUM_GROUPS-1:0] grp_irq_o
);
    logic [BIDX_W-1:0] bank_idx;
    reg_sel_e          reg_sel;
    logic              aligned;

    logic [NUM_BANKS-1:0][REG_W-1:0] en_all;
    logic [NUM_BANKS-1:0][REG_W-1:0] stat_all;

    assign bank_idx = reg_addr_i[ADDR_W-1:4];
    assign reg_sel  = reg_sel_e'(reg_addr_i[3:2]);
    assign aligned  = (reg_addr_i[1:0] == 2'b00);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int REM   = NUM_GROUPS - b * LANES_PER_BANK;
        localparam int LANES = (REM >= LANES_PER_BANK) ? LANES_PER_BANK : REM;

        comb_bank #(.LANES(LANES)) i_bank (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .sel_i   (aligned && bank_idx == BIDX_W'(b)),
            .we_i    (reg_we_i),
            .reg_i   (reg_sel),
            .wdata_i (reg_wdata_i),
            .src_i   (src_i[b*REG_W +: LANES*LANE_W]),
            .en_o    (en_all[b]),
            .stat_o  (stat_all[b]),
            .irq_o   (grp_irq_o[b*LANES_PER_BANK +: LANES])
        );
    end

    comb_rd_mux #(.NUM_BANKS(NUM_BANKS), .BIDX_W(BIDX_W)) i_rd_mux (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .valid_i (aligned),
        .bank_i  (bank_idx),
        .reg_i   (reg_sel),
        .en_i    (en_all),
        .stat_i  (stat_all),
        .rdata_o (reg_rdata_o)
    );
endmodule

// File: tb/test_intr_combiner_top.sv
`timescale 1ns/1ps
module test_intr_combiner_top;
    localparam int NG = 20;
    localparam int NS = NG * 8;
    localparam int NB = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic [7:0]    addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NG-1:0] irq;

    logic [31:0] model_en [NB];
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    intr_combiner_top i_intr_combiner_top (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_addr_i(addr),
        .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .grp_irq_o(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = 8'h08;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    function automatic logic [NG-1:0] exp_irq();
        logic [NG-1:0] r;
        for (int g = 0; g < NG; g++)
            r[g] = |(model_en[g/4][(g%4)*8 +: 8] & src[g*8 +: 8]);
        return r;
    endfunction

    task automatic check_all(string tag);
        logic [31:0] v;
        for (int b = 0; b < NB; b++) begin
            rd(8'(b*16), v);
            chk({tag, " R4 enable readback"}, v, model_en[b]);
            rd(8'(b*16 + 12), v);
            chk({tag, " R5 status"}, v, model_en[b] & src[b*32 +: 32]);
        end
        #1 chk({tag, " R6 group lines"}, 32'(irq), 32'(exp_irq()));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        src = '1;
        for (int b = 0; b < NB; b++) model_en[b] = '0;
        #1 chk("R1 outputs low after reset", 32'(irq), 32'h0);
        for (int b = 0; b < NB; b++) begin
            rd(8'(b*16), v);
            chk("R1 enables zero", v, 32'h0);
        end
    endtask

    task automatic t_set();
        src = '1;
        wr(8'h00, 32'h0000_00A5); model_en[0] |= 32'h0000_00A5;
        check_all("R2 set lane0");
        wr(8'h00, 32'h0000_0000);
        check_all("R2 zero write no change");
        wr(8'h00, 32'h0300_0000); model_en[0] |= 32'h0300_0000;
        check_all("R2 set lane3");
    endtask

    task automatic t_clear();
        wr(8'h04, 32'h0100_0021); model_en[0] &= ~32'h0100_0021;
        check_all("R3 clear");
        wr(8'h04, 32'h0);
        check_all("R3 zero write no change");
    endtask

    task automatic t_isolation();
        for (int b = 1; b < NB; b++) begin
            wr(8'(b*16), 32'h1111_1111 * b); model_en[b] |= 32'h1111_1111 * b;
        end
        wr(8'h20, 32'hFFFF_FFFF); model_en[2] = 32'hFFFF_FFFF;
        check_all("R8 other banks kept");
        wr(8'h34, 32'h00FF_0000); model_en[3] &= ~32'h00FF_0000;
        check_all("R8 clear one lane");
    endtask

    task automatic t_sources();
        logic [31:0] lfsr = 32'hACE1_2357;
        for (int p = 0; p < 6; p++) begin
            for (int w = 0; w < NS/32; w++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                src[w*32 +: 32] = lfsr;
            end
            check_all("R6 pattern");
        end
        src = '0;
        src[77] = 1'b1;
        #1 chk("R6 single source 77 -> group 9", 32'(irq), 32'(exp_irq()));
        wr(8'h24, 32'h0000_2000); model_en[2] &= ~32'h0000_2000;
        #1 chk("R6 source 77 masked", 32'(irq[9]), 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        src = '1;
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'hF4, 32'hFFFF_FFFF);
        check_all("R7 ignored writes");
        rd(8'h04, v);  chk("R7 clear reads zero", v, 32'h0);
        rd(8'h28, v);  chk("R7 offset 0x8 reads zero", v, 32'h0);
        rd(8'h22, v);  chk("R7 misaligned reads zero", v, 32'h0);
        rd(8'h50, v);  chk("R7 beyond last bank reads zero", v, 32'h0);
        rd(8'h5C, v);  chk("R7 beyond last bank status zero", v, 32'h0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_set();
                t_clear();
                t_isolation();
                t_sources();
                t_ignored();
            end
            begin
                repeat (200000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule